// File: doc/BRIEF.md
# Cascadable Presettable 4-Bit Counter

This block is a 4-bit synchronous up-counter. Two parameters fix its flavour when it is built. One picks the count range: binary, modulo 16, or decade, modulo 10. The other decides how the active-low clear acts. It can clear at once, whatever the clock is doing, or only at the next rising clock edge.

A low on the load input copies a 4-bit preset word into the counter at the next rising edge. The count enables have no say in this. Counting needs both enables high: the local enable and the chain enable.

The carry output is high only when the chain enable is high and the counter sits at its terminal state: 15 in binary mode, 9 in decade mode. The carry has no register, so it follows the chain enable without waiting for a clock edge. Several stages form one wide synchronous counter on a shared clock. Each stage's carry drives the chain enable of the stage above it, and no extra gating is needed.

Top module: `cnt4_stage`

## Requirements
- R1: When `ASYNC_CLR` is 1, a low `clear_n_i` forces `count_o` to 0 at once, with no clock edge needed, and holds it at 0 for as long as the clear stays low.
- R2: When `ASYNC_CLR` is 0, a low `clear_n_i` sets `count_o` to 0 only at a rising edge where the clear is sampled low. A clear pulse that starts and ends between two edges leaves the count unchanged.
- R3: When the clear is inactive and `load_n_i` is sampled low at a rising edge, `count_o` takes `preset_i` at that edge, whatever the two enables are. A clear has priority over a load.
- R4: When clear and load are both inactive, the counter advances by one step at a rising edge only if `en_count_i` and `en_chain_i` are both sampled high.
- R5: When clear and load are both inactive and either enable is low at the edge, `count_o` holds its value.
- R6: In binary mode (`DECADE`=0), counting steps from 15 to 0.
- R7: In decade mode (`DECADE`=1), counting steps from 9 to 0. From a loaded value of 10 to 14 it steps to the next binary value, and from 15 it steps to 0.
- R8: `carry_o` is high exactly when `en_chain_i` is high and `count_o` equals the terminal state (15 binary, 9 decade). It follows `en_chain_i` with no clock edge.
- R9: The enables are sampled only at the rising edge. A change of either enable between edges that is undone before the next edge has no effect on `count_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| clear_n_i | input | 1 | Active-low clear, asynchronous or synchronous per `ASYNC_CLR` |
| load_n_i | input | 1 | Active-low synchronous parallel load |
| preset_i | input | 4 | Value loaded when `load_n_i` is low |
| en_count_i | input | 1 | Local count enable, active high |
| en_chain_i | input | 1 | Chain count enable, active high; also gates `carry_o` |
| count_o | output | 4 | Current count |
| carry_o | output | 1 | Terminal-count carry for the next stage's chain enable |

## Verification
The assertions check several rules at every clock edge:
- a load lands the sampled preset word;
- a step happens only with both enables high;
- the count holds otherwise;
- the carry never rises without the chain enable and an odd count;
- the count reads zero whenever the clear is low at an edge.

Other behaviour only shows between clock edges, so only the bench's scenarios can show it. Examples are the immediate effect of an asynchronous clear pulse, the lack of effect of a short synchronous clear pulse, and enable glitches. The decade walk out of the unused states 10 to 15 is also shown only by the bench. The bench runs all four parameter combinations side by side on shared stimulus.

// File: rtl/cnt4_pkg.sv
package cnt4_pkg;

    localparam int CNT_W = 4;

    typedef struct packed {
        logic [CNT_W-1:0] value;
    } cnt_state_t;

    // Last state before wrap: 9 for decade, all ones for binary.
    function automatic logic [CNT_W-1:0] terminal_of(input bit decade);
        logic [CNT_W-1:0] t;
        t = decade ? CNT_W'(9) : {CNT_W{1'b1}};
        return t;
    endfunction

endpackage

// File: rtl/cnt4_step.sv
module cnt4_step
    import cnt4_pkg::*;
#(
    parameter bit DECADE = 1'b0
) (
    input  logic [CNT_W-1:0] cur_i,
    output logic [CNT_W-1:0] inc_o
);

    localparam logic [CNT_W-1:0] TERM = terminal_of(DECADE);

    generate
        if (DECADE) begin : g_dec
            // 9 wraps to 0; 10..14 just increment; 15 overflows to 0.
            always_comb begin
                if (cur_i == TERM) inc_o = '0;
                else               inc_o = cur_i + CNT_W'(1);
            end
        end else begin : g_bin
            always_comb inc_o = cur_i + CNT_W'(1);
        end
    endgenerate

endmodule

// File: rtl/cnt4_carry.sv
module cnt4_carry
    import cnt4_pkg::*;
#(
    parameter bit DECADE = 1'b0
) (
    input  logic [CNT_W-1:0] cur_i,
    input  logic             chain_i,
    output logic             carry_o
);

    localparam logic [CNT_W-1:0] TERM = terminal_of(DECADE);

    always_comb carry_o = chain_i && (cur_i == TERM);

endmodule

// File: rtl/cnt4_next.sv
module cnt4_next
    import cnt4_pkg::*;
(
    input  cnt_state_t       state_q_i,
    input  logic             clr_req_i,
    input  logic             load_n_i,
    input  logic [CNT_W-1:0] preset_i,
    input  logic             en_count_i,
    input  logic             en_chain_i,
    input  logic [CNT_W-1:0] inc_i,
    output cnt_state_t       state_d_o
);

    // Priority: clear, load, count, hold.
    always_comb begin
        state_d_o = state_q_i;
        if (clr_req_i) begin
            state_d_o.value = '0;
        end else if (!load_n_i) begin
            state_d_o.value = preset_i;
        end else if (en_count_i && en_chain_i) begin
            state_d_o.value = inc_i;
        end
    end

endmodule

// File: rtl/cnt4_stage.sv
module cnt4_stage
    import cnt4_pkg::*;
#(
    parameter bit DECADE    = 1'b0,
    parameter bit ASYNC_CLR = 1'b0
) (
    input  logic             clk_i,
    input  logic             clear_n_i,
    input  logic             load_n_i,
    input  logic [CNT_W-1:0] preset_i,
    input  logic             en_count_i,
    input  logic             en_chain_i,
    output logic [CNT_W-1:0] count_o,
    output logic             carry_o
);

    cnt_state_t       state_d;
    cnt_state_t       state_q;
    logic [CNT_W-1:0] inc_val;
    logic             clr_req;

    // The synchronous variant folds the clear into the next-state logic.
    always_comb clr_req = !ASYNC_CLR && !clear_n_i;

    cnt4_step #(.DECADE(DECADE)) step_i (
        .cur_i (state_q.value),
        .inc_o (inc_val)
    );

    cnt4_next next_i (
        .state_q_i  (state_q),
        .clr_req_i  (clr_req),
        .load_n_i   (load_n_i),
        .preset_i   (preset_i),
        .en_count_i (en_count_i),
        .en_chain_i (en_chain_i),
        .inc_i      (inc_val),
        .state_d_o  (state_d)
    );

    cnt4_carry #(.DECADE(DECADE)) carry_i (
        .cur_i   (state_q.value),
        .chain_i (en_chain_i),
        .carry_o (carry_o)
    );

    generate
        if (ASYNC_CLR) begin : g_aclr
            always_ff @(posedge clk_i or negedge clear_n_i) begin
                if (!clear_n_i) state_q <= '0;
                else            state_q <= state_d;
            end

            AST_ASYNC_CLEAR_ZERO: assert property (@(posedge clk_i)
                !clear_n_i |-> (count_o == '0)); // R1
        end else begin : g_sclr
            always_ff @(posedge clk_i) begin
                state_q <= state_d;
            end

            AST_SYNC_CLEAR_EDGE: assert property (@(posedge clk_i)
                !clear_n_i |=> (count_o == '0)); // R2
        end
    endgenerate

    assign count_o = state_q.value;

    // With an asynchronous clear, a pulse between edges may legally zero the count.
    AST_LOAD_TAKES_PRESET: assert property (@(posedge clk_i) disable iff (!clear_n_i)
        !load_n_i |=> (count_o == $past(preset_i)) || (ASYNC_CLR && count_o == '0)); // R3

    AST_STEP_NEEDS_BOTH: assert property (@(posedge clk_i) disable iff (!clear_n_i)
        load_n_i && en_count_i && en_chain_i
        |=> (count_o == $past(inc_val)) || (ASYNC_CLR && count_o == '0)); // R4

    AST_HOLD_WITHOUT_BOTH: assert property (@(posedge clk_i) disable iff (!clear_n_i)
        load_n_i && !(en_count_i && en_chain_i)
        |=> $stable(count_o) || (ASYNC_CLR && count_o == '0)); // R5

    AST_CARRY_NEEDS_CHAIN: assert property (@(posedge clk_i) disable iff (!clear_n_i)
        carry_o |-> (en_chain_i && count_o[0])); // R8

endmodule

// File: tb/cnt4_stage_tb_top.sv
module cnt4_stage_tb_top;

    localparam int CLK_P = 10;
    localparam int NV    = 4;

    logic       clk = 1'b0;
    logic       clear_n = 1'b0;
    logic       load_n = 1'b1;
    logic [3:0] preset = 4'd0;
    logic       en_p = 1'b0;
    logic       en_t = 1'b0;

    logic [3:0] q_w  [NV];
    logic       co_w [NV];
    logic [3:0] ref_q [NV];

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    // Variant v: bit0 = decade, bit1 = asynchronous clear.
    for (genvar v = 0; v < NV; v++) begin : g_var
        cnt4_stage #(
            .DECADE    ((v % 2) == 1),
            .ASYNC_CLR ((v / 2) == 1)
        ) dut_i (
            .clk_i      (clk),
            .clear_n_i  (clear_n),
            .load_n_i   (load_n),
            .preset_i   (preset),
            .en_count_i (en_p),
            .en_chain_i (en_t),
            .count_o    (q_w[v]),
            .carry_o    (co_w[v])
        );
    end

    function automatic bit is_dec(int v);
        return (v % 2) == 1;
    endfunction

    function automatic bit is_async(int v);
        return (v / 2) == 1;
    endfunction

    function automatic logic [3:0] ref_next(logic [3:0] cur, bit dec, bit ld_n,
                                            logic [3:0] d, bit p, bit t);
        if (!ld_n) return d;
        if (!(p && t)) return cur;
        if (dec && cur == 4'd9) return 4'd0;
        return cur + 4'd1;
    endfunction

    function automatic bit ref_carry(logic [3:0] cur, bit dec, bit t);
        return t && (cur == (dec ? 4'd9 : 4'd15));
    endfunction

    task automatic check_val(string req, int v, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s variant %0d at %0t: actual %0d expected %0d", req, v, $time, act, exp);
        end
    endtask

    task automatic check_all(string req);
        for (int v = 0; v < NV; v++) begin
            check_val(req, v, q_w[v], ref_q[v]);
            check_val("R8", v, {3'b0, co_w[v]}, {3'b0, ref_carry(ref_q[v], is_dec(v), en_t)});
        end
    endtask

    // One clock period: drive, optional mid-cycle events, edge, compare.
    task automatic cycle(bit c, bit l, logic [3:0] d, bit p, bit t, bit pulse, bit glitch);
        string tag;
        clear_n = c; load_n = l; preset = d; en_p = p; en_t = t;
        for (int v = 0; v < NV; v++) if (is_async(v) && !c) ref_q[v] = 4'd0;
        #1;
        check_all(c ? "R8" : "R1");
        if (glitch) begin
            en_p = ~p; en_t = ~t;
            #1;
            en_p = p; en_t = t;
        end
        if (pulse && c) begin
            clear_n = 1'b0;
            #1;
            for (int v = 0; v < NV; v++) if (is_async(v)) ref_q[v] = 4'd0;
            check_all("R1 R2");
            clear_n = 1'b1;
        end
        @(posedge clk);
        #1;
        for (int v = 0; v < NV; v++) begin
            if (!c) ref_q[v] = 4'd0;
            else    ref_q[v] = ref_next(ref_q[v], is_dec(v), l, d, p, t);
        end
        if (!c)            tag = "R1 R2";
        else if (!l)       tag = "R3";
        else if (p && t)   tag = "R4 R6 R7";
        else if (glitch)   tag = "R9";
        else               tag = "R5";
        check_all(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog expired at %0t: actual hung expected finished", $time);
        finish_run();
    end

    initial begin
        void'($urandom(32'h0C0FFEE5));
        for (int v = 0; v < NV; v++) ref_q[v] = 4'd0;
        @(posedge clk);
        #1;
        // Reset state under a held clear.
        cycle(1'b0, 1'b1, 4'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        cycle(1'b0, 1'b0, 4'd7, 1'b1, 1'b1, 1'b0, 1'b0); // R3: clear beats load
        // R3: load with both enables low.
        cycle(1'b1, 1'b0, 4'd14, 1'b0, 1'b0, 1'b0, 1'b0);
        // R4/R6: 14 -> 15 (binary carry) -> 0.
        cycle(1'b1, 1'b1, 4'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        cycle(1'b1, 1'b1, 4'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        // R7: load 9 with enables high, then step to 0 in decade.
        cycle(1'b1, 1'b0, 4'd9, 1'b1, 1'b1, 1'b0, 1'b0);
        cycle(1'b1, 1'b1, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0); // R5, carry at 9 with chain high
        cycle(1'b1, 1'b1, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0); // R5, carry low with chain low
        cycle(1'b1, 1'b1, 4'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        // R7: decade out-of-range walk 12, 13, 14, 15, 0.
        cycle(1'b1, 1'b0, 4'd12, 1'b1, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) cycle(1'b1, 1'b1, 4'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        // R9: enables glitch between edges while held low.
        cycle(1'b1, 1'b0, 4'd5, 1'b0, 1'b0, 1'b0, 1'b0);
        cycle(1'b1, 1'b1, 4'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        cycle(1'b1, 1'b1, 4'd0, 1'b1, 1'b0, 1'b0, 1'b1);
        // R1/R2: clear pulse between edges.
        cycle(1'b1, 1'b1, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0);
        cycle(1'b1, 1'b0, 4'd3, 1'b1, 1'b1, 1'b1, 1'b0);
        // Random phase.
        for (int i = 0; i < 3000; i++) begin
            cycle(($urandom % 16) != 0, ($urandom % 6) != 0, 4'($urandom),
                  ($urandom % 4) != 0, ($urandom % 4) != 0,
                  ($urandom % 10) == 0, ($urandom % 8) == 0);
        end
        finish_run();
    end

endmodule